// File: doc/BRIEF.md
# Program Status Word Generator

This block builds the 16-bit status word that a one-time-programmable memory's read path returns while a program operation runs or after one has failed. It takes level and pulse indications from the program sequencer and a strobe for each status read. It registers a status word, together with a select flag that tells the read multiplexer to show that word in place of array data.

The word carries five live fields. Bit 7 is a polling bit that shows the inverse of the target data's bit 7 during a single-word program. Bit 6 flips once per status read. Bit 5 is a sticky failure flag. Bit 4 is a sticky supply-drop flag. Bit 0 is a busy/ready flag used in multi-word mode. All other bits read as 0. The error state stays in place after the sequencer goes idle, so status remains visible until a clear command arrives while no operation is running. Each input is registered once: a stimulus applied before rising edge k is reflected on the outputs right after edge k.

Top module: `prog_status_gen`

## Requirements
- R1: With `rst` high at a rising edge, `stat_word` becomes 0 and `stat_sel` becomes 0 after that edge, whatever the other inputs are.
- R2: After each edge, `stat_sel` is 1 exactly when `op_busy` was 1 at that edge or the error flag (bit 5) is set after it. Whenever `stat_sel` is 0, `stat_word` is 0.
- R3: Bit 7 equals the inverse of `tgt_data[7]` when the word is shown and `op_multi` is 0. It is 0 when `op_multi` is 1.
- R4: Bit 6 inverts at each edge where `rd_stb` is 1 and either `op_busy` is 1 or the error flag was already set. It holds when `rd_stb` is 0. While the block is idle, a read strobe leaves the word at 0.
- R5: Bit 5 sets at an edge where `fail_data` or `fail_vpp` is 1. It stays set after `op_busy` falls.
- R6: Bit 4 sets only on `fail_vpp`. A data failure alone leaves it at 0.
- R7: Bit 0 equals 1 while `op_busy` and `op_multi` are both 1 and `wr_ready` is 0. It is 0 in every other case.
- R8: `clr_err` clears bits 5 and 4 when `op_busy` is 0, which returns `stat_sel` to 0. While `op_busy` is 1, `clr_err` has no effect.
- R9: `op_start` clears the toggle bit and both error flags. A failure pulse at the same edge as `op_start` still sets its flags.
- R10: Bits 3 to 1 and bits 15 to 8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Pulse: a new program operation begins |
| op_busy | input | 1 | Level: the sequencer is programming |
| op_multi | input | 1 | Level: 1 for multi-word mode, 0 for single-word mode |
| fail_data | input | 1 | Pulse: the data was not stored correctly |
| fail_vpp | input | 1 | Pulse: the program supply dropped |
| wr_ready | input | 1 | Level: multi-word controller ready for the next word |
| clr_err | input | 1 | Pulse: decoded reset command |
| rd_stb | input | 1 | Pulse: a status read took place |
| tgt_data | input | 16 | Data word being programmed |
| stat_word | output | 16 | Registered status word |
| stat_sel | output | 1 | Registered select: show status instead of array data |

## Verification
Every field of the status word, and the select flag, is due exactly one rising edge after its stimulus. There are no deeper paths. The bench drives each table row at a falling edge and compares the outputs at the following falling edge, so it always samples the single update that the row caused. Toggle, error latch and clear interact across cycles, so the table walks them as one continuous sequence. Directed cases then cover reset in mid-operation and an idle read.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int ERR_POS  = 5;
  localparam int VPP_POS  = 4;
  localparam int RDY_POS  = 0;
  localparam int MIN_W    = 8;
endpackage

// File: rtl/psr_err_latch.sv
module psr_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic op_start,
  input  logic op_busy,
  input  logic fail_data,
  input  logic fail_vpp,
  input  logic clr_err,
  output logic err_q,
  output logic err_d,
  output logic vpp_d
);
  logic vpp_q;
  logic clr_ok;

  // a clear command is accepted only with no operation under way
  assign clr_ok = op_start | (clr_err & ~op_busy);

  always_comb begin
    err_d = clr_ok ? 1'b0 : err_q;
    vpp_d = clr_ok ? 1'b0 : vpp_q;
    if (fail_data | fail_vpp) err_d = 1'b1;
    if (fail_vpp)             vpp_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      vpp_q <= 1'b0;
    end else begin
      err_q <= err_d;
      vpp_q <= vpp_d;
    end
  end
endmodule

// File: rtl/psr_toggle.sv
module psr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic op_start,
  input  logic rd_stb,
  input  logic live,
  output logic tog_d
);
  logic tog_q;

  always_comb begin
    if (op_start)            tog_d = 1'b0;
    else if (rd_stb && live) tog_d = ~tog_q;
    else                     tog_d = tog_q;
  end

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_d;
  end
endmodule

// File: rtl/psr_pack.sv
module psr_pack #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         show,
  input  logic         multi,
  input  logic         busy,
  input  logic         ready,
  input  logic         tgt_msb,
  input  logic         tog,
  input  logic         err,
  input  logic         vpp,
  output logic [W-1:0] word_q,
  output logic         sel_q
);
  import psr_pkg::*;

  logic [W-1:0] word_d;

  always_comb begin
    word_d = '0;
    if (show) begin
      word_d[POLL_POS] = ~multi & ~tgt_msb;
      word_d[TOG_POS]  = tog;
      word_d[ERR_POS]  = err;
      word_d[VPP_POS]  = vpp;
      word_d[RDY_POS]  = busy & multi & ~ready;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      sel_q  <= show;
    end
  end
endmodule

// File: rtl/prog_status_gen.sv
module prog_status_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_busy,
  input  logic          op_multi,
  input  logic          fail_data,
  input  logic          fail_vpp,
  input  logic          wr_ready,
  input  logic          clr_err,
  input  logic          rd_stb,
  input  logic [DW-1:0] tgt_data,
  output logic [DW-1:0] stat_word,
  output logic          stat_sel
);
  import psr_pkg::*;

  logic err_q, err_d, vpp_d, tog_d;
  logic live, show;

  generate
    if (DW < MIN_W) begin : g_bad_width
      initial $error("prog_status_gen: DW below minimum");
    end
  endgenerate

  psr_err_latch u_err (
    .clk(clk), .rst(rst), .op_start(op_start), .op_busy(op_busy),
    .fail_data(fail_data), .fail_vpp(fail_vpp), .clr_err(clr_err),
    .err_q(err_q), .err_d(err_d), .vpp_d(vpp_d)
  );

  // reads count while the operation runs or an error is pending
  assign live = op_busy | err_q;
  assign show = op_busy | err_d;

  psr_toggle u_tog (
    .clk(clk), .rst(rst), .op_start(op_start), .rd_stb(rd_stb),
    .live(live), .tog_d(tog_d)
  );

  psr_pack #(.W(DW)) u_pack (
    .clk(clk), .rst(rst), .show(show), .multi(op_multi), .busy(op_busy),
    .ready(wr_ready), .tgt_msb(tgt_data[POLL_POS]), .tog(tog_d),
    .err(err_d), .vpp(vpp_d), .word_q(stat_word), .sel_q(stat_sel)
  );
endmodule

// File: rtl/prog_status_gen_chk.sv
module prog_status_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          op_start,
  input logic          op_busy,
  input logic          op_multi,
  input logic          fail_data,
  input logic          fail_vpp,
  input logic          wr_ready,
  input logic          clr_err,
  input logic          rd_stb,
  input logic [DW-1:0] tgt_data,
  input logic [DW-1:0] stat_word,
  input logic          stat_sel
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_RESET_ZERO: assert property (@(posedge clk)
    seen && $past(rst) |-> (stat_word == '0) && !stat_sel); // R1

  AST_BUSY_SELECTS: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(op_busy) |-> stat_sel); // R2

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
    !stat_sel |-> stat_word == '0); // R2

  AST_POLL_INV: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(op_busy) && !$past(op_multi)
    |-> stat_word[7] == !$past(tgt_data[7])); // R3

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(rd_stb) && $past(op_busy) && !$past(op_start) && $past(stat_sel)
    |-> stat_word[6] != $past(stat_word[6])); // R4

  AST_FAIL_SETS: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && ($past(fail_data) || $past(fail_vpp)) |-> stat_word[5]); // R5

  AST_VPP_SETS: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(fail_vpp) |-> stat_word[4]); // R6

  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(stat_word[5]) && $past(op_busy) && !$past(op_start)
    |-> stat_word[5]); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_word[3:1] == 3'b000 && stat_word[DW-1:8] == '0); // R10
endmodule

bind prog_status_gen prog_status_gen_chk #(.DW(DW)) u_chk (.*);

// File: tb/prog_status_gen_test.sv
module prog_status_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NROWS = 18;
  // row: {start,busy,multi,fdat,fvpp,rdy,clr,rd, tgt[7:0], exp_word[15:0], exp_sel}
  localparam logic [32:0] ROWS [NROWS] = '{
    {8'b1100_0000, 8'h80, 16'h0000, 1'b1}, // 0 R9 R3 start single
    {8'b0100_0001, 8'h00, 16'h00C0, 1'b1}, // 1 R4 R3
    {8'b0100_0000, 8'h00, 16'h00C0, 1'b1}, // 2 R4 hold
    {8'b0100_0001, 8'h00, 16'h0080, 1'b1}, // 3 R4
    {8'b0000_0000, 8'h00, 16'h0000, 1'b0}, // 4 R2 success
    {8'b1110_0000, 8'h00, 16'h0001, 1'b1}, // 5 R7 multi busy
    {8'b0110_0101, 8'h00, 16'h0040, 1'b1}, // 6 R7 ready
    {8'b0110_0001, 8'h00, 16'h0001, 1'b1}, // 7 R7 R3
    {8'b0111_0000, 8'h00, 16'h0021, 1'b1}, // 8 R5 R6
    {8'b0010_0001, 8'h00, 16'h0060, 1'b1}, // 9 R5 R4 error idle
    {8'b0000_0010, 8'h00, 16'h0000, 1'b0}, // 10 R8 clear
    {8'b1100_1000, 8'h7F, 16'h00B0, 1'b1}, // 11 R6 R3
    {8'b0100_0010, 8'h7F, 16'h00B0, 1'b1}, // 12 R8 blocked
    {8'b0000_0001, 8'h7F, 16'h00F0, 1'b1}, // 13 R4 R2
    {8'b0000_0010, 8'h7F, 16'h0000, 1'b0}, // 14 R8
    {8'b1101_0000, 8'hFF, 16'h0020, 1'b1}, // 15 R9 fail with start
    {8'b0000_0010, 8'hFF, 16'h0000, 1'b0}, // 16 R8
    {8'b0000_0001, 8'hFF, 16'h0000, 1'b0}  // 17 R4 idle read, R10
  };

  logic clk = 1'b0;
  logic rst, op_start, op_busy, op_multi, fail_data, fail_vpp, wr_ready, clr_err, rd_stb;
  logic [DW-1:0] tgt_data, stat_word;
  logic stat_sel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_status_gen #(.DW(DW)) uut (.*);

  function automatic string row_tag(int i);
    case (i)
      0: return "R9/R3"; 1, 2, 3, 13, 17: return "R4"; 4: return "R2";
      5, 6, 7: return "R7"; 8: return "R6"; 9: return "R5";
      10, 12, 14, 16: return "R8"; 11: return "R6/R3"; default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] ew, logic es);
    checks++;
    if (stat_word !== ew || stat_sel !== es) begin
      errors++;
      $display("FAIL %s word=%h sel=%b expected word=%h sel=%b", tag, stat_word, stat_sel, ew, es);
    end
  endtask

  task automatic idle_inputs();
    {op_start, op_busy, op_multi, fail_data, fail_vpp, wr_ready, clr_err, rd_stb} = '0;
    tgt_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    op_busy = 1'b1; rd_stb = 1'b1; fail_vpp = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst = 1'b0; idle_inputs();
    @(negedge clk);
    check("R1 after reset", '0, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      {op_start, op_busy, op_multi, fail_data, fail_vpp, wr_ready, clr_err, rd_stb} = ROWS[i][32:25];
      tgt_data = {8'h00, ROWS[i][24:17]};
      @(negedge clk);
      check(row_tag(i), ROWS[i][16:1], ROWS[i][0]);
    end

    // R10: upper target bits never reach the word
    idle_inputs(); op_start = 1'b1; op_busy = 1'b1; tgt_data = 16'hFF7F;
    @(negedge clk);
    check("R10 upper bits", 16'h0080, 1'b1);

    // R1: reset in the middle of a failed operation
    op_start = 1'b0; fail_vpp = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    check("R6 before reset", 16'h00F0, 1'b1);
    rst = 1'b1; fail_vpp = 1'b0;
    @(negedge clk);
    check("R1 mid-op reset", '0, 1'b0);
    rst = 1'b0; idle_inputs(); rd_stb = 1'b1;
    @(negedge clk);
    check("R4 idle read", '0, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule